// File: doc/BRIEF.md
# Hardwired Multi-Cycle Instruction Sequencer

This block is the control unit of a small multi-cycle processor. It has no microcode store. A short step counter serves as the state register. Combinational logic decodes the counter value together with the current opcode and produces the datapath control strobes for that cycle.

Every instruction starts with a fetch step. In the fetch step the instruction register is loaded and the program counter is advanced. Ordinary instructions need one execute step. During that step the control logic clears the counter, so these instructions take two cycles. The indirect load (opcode `3'b110`) reads a pointer into a temporary register in its first execute step and keeps counting. It then writes the pointed-to word into the destination register in a second execute step, so it takes three cycles.

The opcode input models the output of the instruction register. It must be valid from the cycle after fetch until the instruction ends. Every pin is plain control: there is no data stream and no handshake.

Top module: `hw_sequencer`

## Requirements
- R1: While `rst_n` is low, `step` reads 0 and the outputs show the fetch step. The first cycle after reset is released is a fetch.
- R2: In step 0 (fetch), for any opcode, the outputs are: `ir_load`=1, `pc_inc`=1, `addr_sel`=0, `reg_wr`=0, `tmp_wr`=0, `func_sel`=0.
- R3: While the decode does not request a clear, `step` rises by exactly one on each clock.
- R4: For any opcode other than `3'b110`, step 1 drives `reg_wr`=1 and `func_sel` = opcode zero-extended. All other strobes in step 1 are 0. The next cycle is fetch, so the instruction lasts 2 cycles.
- R5: For opcode `3'b110`, step 1 drives `addr_sel`=1 (register-sourced address) and `tmp_wr`=1. All other strobes in this step are 0, and `func_sel` is 0. The sequence continues to step 2.
- R6: Step 2 drives `addr_sel`=1 and `reg_wr`=1. All other strobes in step 2 are 0, and `func_sel` is 0 (pass-through). The next cycle is fetch, so the indirect load lasts 3 cycles.
- R7: `step` never shows 3 in operation. If value 3 is ever reached, every strobe is 0 and the next cycle is fetch.
- R8: `reg_wr` and `tmp_wr` are never high together, and `ir_load` is high only in step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 3 | Opcode of the current instruction |
| ir_load | output | 1 | Load the instruction register |
| pc_inc | output | 1 | Advance the program counter |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = register |
| reg_wr | output | 1 | Write the register file |
| tmp_wr | output | 1 | Write the temporary register |
| func_sel | output | 4 | Function-unit operation select |
| step | output | 2 | Current sequence step |

## Verification
The bench runs back-to-back indirect loads. A counter that cleared after the first execute step, or one that never cleared after the second, would give those instructions the wrong length. It mixes these with runs of simple opcodes, including `3'b111` and `3'b000` next to `3'b110`, because a sloppy opcode compare there would misroute them. The bench changes the opcode during fetch to show that fetch strobes do not depend on it. It also asserts reset in the middle of an indirect load: a counter that did not return to fetch at once, or that went on in step 2, is caught.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STEP_W = 2;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH = 2'd0,
    ST_EX0   = 2'd1,
    ST_EX1   = 2'd2,
    ST_SPARE = 2'd3
  } step_e;
endpackage

// File: rtl/seq_step_ctr.sv
module seq_step_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] step
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step <= '0;
    else if (clear) step <= '0;
    else            step <= step + ONE;
  end

  AST_CLEAR_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (step == '0)); // R1
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (step == $past(step) + ONE)); // R3
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int OPC_W = 3,
  parameter int FUNC_W = 4,
  parameter logic [OPC_W-1:0] IND_OPC = 3'b110
) (
  input  logic [STEP_W-1:0] step,
  input  logic [OPC_W-1:0]  opcode,
  output logic              ir_load,
  output logic              pc_inc,
  output logic              addr_sel,
  output logic              reg_wr,
  output logic              tmp_wr,
  output logic [FUNC_W-1:0] func_sel,
  output logic              clear
);
  logic [FUNC_W-1:0] op_func;
  logic              is_ind;

  generate
    if (FUNC_W > OPC_W) begin : g_pad
      assign op_func = {{(FUNC_W-OPC_W){1'b0}}, opcode};
    end else begin : g_trunc
      assign op_func = opcode[FUNC_W-1:0];
    end
  endgenerate

  assign is_ind = (opcode == IND_OPC);

  always_comb begin
    ir_load  = 1'b0;
    pc_inc   = 1'b0;
    addr_sel = 1'b0;
    reg_wr   = 1'b0;
    tmp_wr   = 1'b0;
    func_sel = '0;
    clear    = 1'b0;
    unique case (step_e'(step))
      ST_FETCH: begin
        ir_load = 1'b1;
        pc_inc  = 1'b1;
      end
      ST_EX0: begin
        if (is_ind) begin
          addr_sel = 1'b1;
          tmp_wr   = 1'b1;
        end else begin
          reg_wr   = 1'b1;
          func_sel = op_func;
          clear    = 1'b1;
        end
      end
      ST_EX1: begin
        addr_sel = 1'b1;
        reg_wr   = 1'b1;
        clear    = 1'b1;
      end
      default: clear = 1'b1;
    endcase
  end

  always_comb begin
    if (step == ST_FETCH)
      AST_FETCH_NO_END: assert (!clear && !reg_wr && !tmp_wr); // R2
    if (step == ST_SPARE)
      AST_SPARE_QUIET: assert (clear && !reg_wr && !tmp_wr && !ir_load); // R7
  end
endmodule

// File: rtl/hw_sequencer.sv
module hw_sequencer
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  opcode,
  output logic        ir_load,
  output logic        pc_inc,
  output logic        addr_sel,
  output logic        reg_wr,
  output logic        tmp_wr,
  output logic [3:0]  func_sel,
  output logic [1:0]  step
);
  localparam int OPC_W  = 3;
  localparam int FUNC_W = 4;
  localparam logic [OPC_W-1:0] IND_OPC = 3'b110;

  logic clear;

  seq_step_ctr #(.W(STEP_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (step)
  );

  seq_decode #(.OPC_W(OPC_W), .FUNC_W(FUNC_W), .IND_OPC(IND_OPC)) u_dec (
    .step     (step),
    .opcode   (opcode),
    .ir_load  (ir_load),
    .pc_inc   (pc_inc),
    .addr_sel (addr_sel),
    .reg_wr   (reg_wr),
    .tmp_wr   (tmp_wr),
    .func_sel (func_sel),
    .clear    (clear)
  );

  AST_IND_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd1 && opcode == IND_OPC) |=> (step == 2'd2)); // R5
  AST_SIMPLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd1 && opcode != IND_OPC) |=> (step == 2'd0)); // R4
  AST_EX1_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd2) |=> (step == 2'd0)); // R6
  AST_NO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    step != 2'd3); // R7
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && tmp_wr) && (!ir_load || step == 2'd0)); // R8
endmodule

// File: tb/hw_sequencer_test.sv
`timescale 1ns/1ps
module hw_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] opcode = 3'b000;
  logic       ir_load, pc_inc, addr_sel, reg_wr, tmp_wr;
  logic [3:0] func_sel;
  logic [1:0] step;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hw_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .ir_load(ir_load), .pc_inc(pc_inc), .addr_sel(addr_sel),
    .reg_wr(reg_wr), .tmp_wr(tmp_wr), .func_sel(func_sel), .step(step)
  );

  // packed {ir_load, pc_inc, addr_sel, reg_wr, tmp_wr, func_sel[3:0]}
  function automatic logic [8:0] exp_ctrl(input int k, input logic [2:0] op);
    case (k)
      0: return {5'b11000, 4'h0};
      1: return (op == 3'b110) ? {5'b00101, 4'h0} : {5'b00010, 1'b0, op};
      2: return {5'b00110, 4'h0};
      default: return 9'h0;
    endcase
  endfunction

  function automatic int exp_len(input logic [2:0] op);
    return (op == 3'b110) ? 3 : 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] got();
    return {ir_load, pc_inc, addr_sel, reg_wr, tmp_wr, func_sel};
  endfunction

  // Entry and exit: at a negedge with step == 0.
  task automatic run_instr(input logic [2:0] op);
    int cyc = 0;
    opcode = ~op;          // fetch must ignore the opcode (R2)
    #1;
    chk(got() == exp_ctrl(0, op), "R2", got(), exp_ctrl(0, op));
    opcode = op;
    #1;
    for (int k = 0; k < 5; k++) begin
      chk(step == 2'(k), "R3", step, k);
      chk(step != 2'd3, "R7", step, 0);
      chk(got() == exp_ctrl(k, op),
          (k == 0) ? "R2" : (op == 3'b110 ? (k == 1 ? "R5" : "R6") : "R4"),
          got(), exp_ctrl(k, op));
      chk(!(reg_wr && tmp_wr) && (!ir_load || step == 2'd0), "R8", got(), 0);
      cyc++;
      @(posedge clk);
      @(negedge clk);
      #1;
      if (step == 2'd0) break;
    end
    chk(cyc == exp_len(op), (op == 3'b110) ? "R6" : "R4", cyc, exp_len(op));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(step == 2'd0, "R1", step, 0);
    chk(got() == exp_ctrl(0, 3'b000), "R1", got(), exp_ctrl(0, 3'b000));
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(step == 2'd1, "R1", step, 1);
    // return to a fetch boundary
    while (step != 2'd0) begin @(posedge clk); @(negedge clk); #1; end

    // directed corners
    run_instr(3'b110);
    run_instr(3'b110);
    run_instr(3'b111);
    run_instr(3'b110);
    run_instr(3'b000);
    for (int o = 0; o < 8; o++) run_instr(3'(o));

    // reset in the middle of an indirect load (R1)
    opcode = 3'b110;
    @(posedge clk); @(negedge clk); #1;
    chk(step == 2'd1, "R5", step, 1);
    rst_n = 1'b0;
    #1;
    chk(step == 2'd0, "R1", step, 0);
    chk(ir_load && pc_inc && !tmp_wr, "R1", got(), exp_ctrl(0, 3'b110));
    @(posedge clk); @(negedge clk); #1;
    chk(step == 2'd0, "R1", step, 0);
    rst_n = 1'b1;
    #1;
    run_instr(3'b011);

    // constrained random stream, indirect loads weighted up
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = ($urandom % 4 == 0) ? 3'b110 : 3'($urandom % 8);
      run_instr(op);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule